// File: doc/BRIEF.md
# Rename History Buffer with Rollback

This block records, in program order, every destination-register rename done by the rename stage of an out-of-order core. Each record holds the instruction's sequence number, the architectural register, the physical register just given to it, the physical register it displaced, and a flag marking a placeholder. An instruction with no destination still leaves one placeholder record so that its sequence number is tracked. The rename map table and the physical free list are outside the block. The block drives a map-restore write port into the map table and a return port into the free list.

When a misprediction squashes younger work, the block walks back from the youngest record. It restores each architectural register to its earlier physical register and hands the newly given register back to the free list. When instructions commit, it walks forward from the oldest record and hands back the displaced physical registers, which can no longer be named. Each walk retires one record per clock. While a walk runs, the block reports busy and accepts no new records or requests. Four counters report placeholder insertions, committed mappings, undone records and undone real mappings.

Top module: `rename_history_buf`

## Requirements
- R1: While `ins_ready` is high, a cycle with `ins_valid` high stores one record at the young end. Records are later removed only at the two ends, so the record order is the insertion order.
- R2: `full` is high when DEPTH records are held. `ins_ready` is then low, and an insertion attempt does not change the contents.
- R3: A squash request with number S removes, youngest first and one per clock, every record whose sequence number is greater than S. For each such record that is not a placeholder, the same cycle shows `map_we` with `map_arch` = its architectural register and `map_phys` = its previous physical register, together with `free_we` with `free_phys` = its new physical register.
- R4: A placeholder removed by a squash or by a commit produces no map write and no free-list return.
- R5: A squash request while the buffer is empty produces no map write and no free-list return, and it leaves every counter unchanged.
- R6: A commit request with number C removes, oldest first and one per clock, every record whose sequence number is at most C. Each such record that is not a placeholder returns its previous physical register on `free_phys`. A commit never raises `map_we`.
- R7: A commit request is ignored when the buffer is empty or its oldest record is younger than C. `busy` stays low and nothing is removed.
- R8: In the same cycle, a squash request wins over a commit request, and any request wins over an insertion. `ins_ready` is low while `sq_valid` or `cmt_valid` is high.
- R9: `busy` is high from the cycle after an accepted request until the walk ends. Requests and insertions offered while `busy` is high are ignored.
- R10: `cnt_hold` counts accepted placeholder insertions. `cnt_commit` counts non-placeholder records removed by commits. `cnt_undo` counts all records removed by squashes. `cnt_undo_valid` counts non-placeholder records removed by squashes.
- R11: After reset the buffer is empty, `busy` and `full` are low, `ins_ready` is high, no write port is active, and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Offer a rename record |
| ins_seq | input | SEQ_W | Sequence number of the instruction |
| ins_arch | input | ARCH_W | Architectural destination register |
| ins_new | input | PHYS_W | Newly given physical register |
| ins_prev | input | PHYS_W | Physical register displaced |
| ins_hold | input | 1 | Record is a placeholder (no destination) |
| ins_ready | output | 1 | Record accepted this cycle if offered |
| cmt_valid | input | 1 | Commit request |
| cmt_seq | input | SEQ_W | Youngest committed sequence number |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Youngest surviving sequence number |
| map_we | output | 1 | Restore write to the map table |
| map_arch | output | ARCH_W | Architectural register restored |
| map_phys | output | PHYS_W | Physical register written back |
| free_we | output | 1 | Return a register to the free list |
| free_phys | output | PHYS_W | Register returned |
| busy | output | 1 | A walk is in progress |
| full | output | 1 | All DEPTH slots in use |
| cnt_hold | output | CNT_W | Placeholder insertions |
| cnt_commit | output | CNT_W | Committed mappings |
| cnt_undo | output | CNT_W | Records undone by squashes |
| cnt_undo_valid | output | CNT_W | Non-placeholder records undone |

## Verification
Directed cases cover squash and commit against an empty buffer, a commit number older than the oldest record, a buffer filled to capacity, simultaneous squash and commit requests, and a commit poked in while a squash walk runs. These separate the ignore rules from the walk rules and show the request priority. Random instruction streams then mix records with zero, one and two destinations and placeholders, and apply squash and commit numbers that land inside, before and beyond the held range. This shows whether walks stop exactly at the boundary, whether placeholders are silent, and whether records sharing a sequence number leave together. Every map and free-list event sequence is compared in order against a queue model in the bench.

// File: rtl/rhb_pkg.sv
package rhb_pkg;
  typedef enum logic [1:0] {
    WALK_IDLE   = 2'd0,
    WALK_SQUASH = 2'd1,
    WALK_COMMIT = 2'd2
  } walk_e;
endpackage

// File: rtl/rhb_store.sv
// Circular record array; DEPTH must be a power of two.
module rhb_store #(
  parameter int DEPTH  = 16,
  parameter int SEQ_W  = 16,
  parameter int ARCH_W = 5,
  parameter int PHYS_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [SEQ_W-1:0]  push_seq,
  input  logic [ARCH_W-1:0] push_arch,
  input  logic [PHYS_W-1:0] push_new,
  input  logic [PHYS_W-1:0] push_prev,
  input  logic              push_hold,
  input  logic              pop_old,
  input  logic              pop_young,
  output logic [SEQ_W-1:0]  old_seq,
  output logic [PHYS_W-1:0] old_prev,
  output logic              old_hold,
  output logic [SEQ_W-1:0]  young_seq,
  output logic [ARCH_W-1:0] young_arch,
  output logic [PHYS_W-1:0] young_new,
  output logic [PHYS_W-1:0] young_prev,
  output logic              young_hold,
  output logic              full,
  output logic              empty
);
  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W   = PTR_W + 1;
  localparam int PREV_LO = 1;
  localparam int NEW_LO  = PREV_LO + PHYS_W;
  localparam int ARCH_LO = NEW_LO + PHYS_W;
  localparam int SEQ_LO  = ARCH_LO + ARCH_W;
  localparam int EW      = SEQ_LO + SEQ_W;

  logic [PTR_W-1:0] head_q, head_d, tail_q, tail_d, yidx;
  logic [CNT_W-1:0] count_q, count_d;
  logic [EW-1:0]    push_ent;
  logic [EW-1:0]    slot_rd [DEPTH];

  assign push_ent = {push_seq, push_arch, push_new, push_prev, push_hold};

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic          wr_en;
      logic [EW-1:0] slot_q;
      assign wr_en = push && (tail_q == PTR_W'(i));
      always_ff @(posedge clk) begin
        if (wr_en) slot_q <= push_ent;
      end
      assign slot_rd[i] = slot_q;
    end
  endgenerate

  assign yidx = tail_q - PTR_W'(1);

  always_comb begin
    head_d  = head_q;
    tail_d  = tail_q;
    count_d = count_q;
    if (push) begin
      tail_d  = tail_q + PTR_W'(1);
      count_d = count_d + CNT_W'(1);
    end
    if (pop_old) begin
      head_d  = head_q + PTR_W'(1);
      count_d = count_d - CNT_W'(1);
    end else if (pop_young) begin
      tail_d  = yidx;
      count_d = count_d - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      head_q  <= head_d;
      tail_q  <= tail_d;
      count_q <= count_d;
    end
  end

  assign full  = (count_q == CNT_W'(DEPTH));
  assign empty = (count_q == '0);

  assign old_seq    = slot_rd[head_q][SEQ_LO +: SEQ_W];
  assign old_prev   = slot_rd[head_q][PREV_LO +: PHYS_W];
  assign old_hold   = slot_rd[head_q][0];
  assign young_seq  = slot_rd[yidx][SEQ_LO +: SEQ_W];
  assign young_arch = slot_rd[yidx][ARCH_LO +: ARCH_W];
  assign young_new  = slot_rd[yidx][NEW_LO +: PHYS_W];
  assign young_prev = slot_rd[yidx][PREV_LO +: PHYS_W];
  assign young_hold = slot_rd[yidx][0];
endmodule

// File: rtl/rhb_ctrl.sv
module rhb_ctrl
  import rhb_pkg::*;
#(
  parameter int SEQ_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sq_valid,
  input  logic [SEQ_W-1:0] sq_seq,
  input  logic             cmt_valid,
  input  logic [SEQ_W-1:0] cmt_seq,
  input  logic             ins_valid,
  input  logic             full,
  input  logic             empty,
  input  logic [SEQ_W-1:0] old_seq,
  input  logic [SEQ_W-1:0] young_seq,
  output logic             push,
  output logic             ins_ready,
  output logic             pop_old,
  output logic             pop_young,
  output logic             busy
);
  walk_e            state_q, state_d;
  logic [SEQ_W-1:0] tgt_q, tgt_in;
  logic             tgt_en;

  always_comb begin
    state_d   = state_q;
    tgt_en    = 1'b0;
    tgt_in    = sq_seq;
    pop_old   = 1'b0;
    pop_young = 1'b0;
    unique case (state_q)
      WALK_IDLE: begin
        if (sq_valid) begin
          state_d = WALK_SQUASH;
          tgt_en  = 1'b1;
          tgt_in  = sq_seq;
        end else if (cmt_valid && !empty && (old_seq <= cmt_seq)) begin
          state_d = WALK_COMMIT;
          tgt_en  = 1'b1;
          tgt_in  = cmt_seq;
        end
      end
      WALK_SQUASH: begin
        if (!empty && (young_seq > tgt_q)) pop_young = 1'b1;
        else                               state_d   = WALK_IDLE;
      end
      WALK_COMMIT: begin
        if (!empty && (old_seq <= tgt_q)) pop_old = 1'b1;
        else                              state_d = WALK_IDLE;
      end
      default: state_d = WALK_IDLE;
    endcase
  end

  assign busy      = (state_q != WALK_IDLE);
  assign ins_ready = !busy && !full && !sq_valid && !cmt_valid;
  assign push      = ins_valid && ins_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= WALK_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (tgt_en) tgt_q <= tgt_in;
  end
endmodule

// File: rtl/rhb_stats.sv
module rhb_stats #(
  parameter int NUM   = 4,
  parameter int CNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM-1:0]            inc,
  output logic [NUM-1:0][CNT_W-1:0] cnt
);
  generate
    for (genvar k = 0; k < NUM; k++) begin : g_cnt
      logic [CNT_W-1:0] cnt_q, cnt_d;
      always_comb cnt_d = cnt_q + CNT_W'(1);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (inc[k]) cnt_q <= cnt_d;
      end
      assign cnt[k] = cnt_q;
    end
  endgenerate
endmodule

// File: rtl/rename_history_buf.sv
module rename_history_buf #(
  parameter int DEPTH  = 16,
  parameter int SEQ_W  = 16,
  parameter int ARCH_W = 5,
  parameter int PHYS_W = 7,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic [SEQ_W-1:0]  ins_seq,
  input  logic [ARCH_W-1:0] ins_arch,
  input  logic [PHYS_W-1:0] ins_new,
  input  logic [PHYS_W-1:0] ins_prev,
  input  logic              ins_hold,
  output logic              ins_ready,
  input  logic              cmt_valid,
  input  logic [SEQ_W-1:0]  cmt_seq,
  input  logic              sq_valid,
  input  logic [SEQ_W-1:0]  sq_seq,
  output logic              map_we,
  output logic [ARCH_W-1:0] map_arch,
  output logic [PHYS_W-1:0] map_phys,
  output logic              free_we,
  output logic [PHYS_W-1:0] free_phys,
  output logic              busy,
  output logic              full,
  output logic [CNT_W-1:0]  cnt_hold,
  output logic [CNT_W-1:0]  cnt_commit,
  output logic [CNT_W-1:0]  cnt_undo,
  output logic [CNT_W-1:0]  cnt_undo_valid
);
  localparam int NUM_CNT = 4;

  logic              push, pop_old, pop_young, empty;
  logic [SEQ_W-1:0]  old_seq, young_seq;
  logic [PHYS_W-1:0] old_prev, young_new, young_prev;
  logic              old_hold, young_hold;
  logic              undo_real, commit_real;
  logic [NUM_CNT-1:0]            cnt_inc;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_all;

  rhb_store #(
    .DEPTH(DEPTH), .SEQ_W(SEQ_W), .ARCH_W(ARCH_W), .PHYS_W(PHYS_W)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (push),
    .push_seq   (ins_seq),
    .push_arch  (ins_arch),
    .push_new   (ins_new),
    .push_prev  (ins_prev),
    .push_hold  (ins_hold),
    .pop_old    (pop_old),
    .pop_young  (pop_young),
    .old_seq    (old_seq),
    .old_prev   (old_prev),
    .old_hold   (old_hold),
    .young_seq  (young_seq),
    .young_arch (map_arch),
    .young_new  (young_new),
    .young_prev (young_prev),
    .young_hold (young_hold),
    .full       (full),
    .empty      (empty)
  );

  rhb_ctrl #(.SEQ_W(SEQ_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sq_valid  (sq_valid),
    .sq_seq    (sq_seq),
    .cmt_valid (cmt_valid),
    .cmt_seq   (cmt_seq),
    .ins_valid (ins_valid),
    .full      (full),
    .empty     (empty),
    .old_seq   (old_seq),
    .young_seq (young_seq),
    .push      (push),
    .ins_ready (ins_ready),
    .pop_old   (pop_old),
    .pop_young (pop_young),
    .busy      (busy)
  );

  assign undo_real   = pop_young && !young_hold;
  assign commit_real = pop_old && !old_hold;

  assign map_we    = undo_real;
  assign map_phys  = young_prev;
  assign free_we   = undo_real || commit_real;
  assign free_phys = pop_young ? young_new : old_prev;

  assign cnt_inc = {undo_real, pop_young, commit_real, push && ins_hold};

  rhb_stats #(.NUM(NUM_CNT), .CNT_W(CNT_W)) u_stats (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (cnt_inc),
    .cnt   (cnt_all)
  );

  assign cnt_hold       = cnt_all[0];
  assign cnt_commit     = cnt_all[1];
  assign cnt_undo       = cnt_all[2];
  assign cnt_undo_valid = cnt_all[3];
endmodule

// File: rtl/rhb_checker.sv
module rhb_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ins_ready,
  input logic             sq_valid,
  input logic             cmt_valid,
  input logic             map_we,
  input logic             free_we,
  input logic             busy,
  input logic             full,
  input logic [CNT_W-1:0] cnt_undo_valid
);
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !ins_ready);

  assert_map_with_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
    map_we |-> free_we);

  assert_writes_in_walk_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (map_we || free_we) |-> busy);

  assert_squash_starts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_valid && !busy) |=> busy);

  assert_request_blocks_insert_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_valid || cmt_valid) |-> !ins_ready);

  assert_idle_when_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ins_ready |-> !busy);

  assert_undo_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    map_we |=> (cnt_undo_valid == $past(cnt_undo_valid) + CNT_W'(1)));
endmodule

bind rename_history_buf rhb_checker #(.CNT_W(CNT_W)) u_rhb_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .ins_ready      (ins_ready),
  .sq_valid       (sq_valid),
  .cmt_valid      (cmt_valid),
  .map_we         (map_we),
  .free_we        (free_we),
  .busy           (busy),
  .full           (full),
  .cnt_undo_valid (cnt_undo_valid)
);

// File: tb/rename_history_buf_bench.sv
module rename_history_buf_bench;
  localparam int DEPTH = 16, SEQ_W = 16, ARCH_W = 5, PHYS_W = 7, CNT_W = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic ins_valid, ins_hold, ins_ready;
  logic [SEQ_W-1:0] ins_seq, cmt_seq, sq_seq;
  logic [ARCH_W-1:0] ins_arch, map_arch;
  logic [PHYS_W-1:0] ins_new, ins_prev, map_phys, free_phys;
  logic cmt_valid, sq_valid, map_we, free_we, busy, full;
  logic [CNT_W-1:0] cnt_hold, cnt_commit, cnt_undo, cnt_undo_valid;

  rename_history_buf #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .ARCH_W(ARCH_W),
                       .PHYS_W(PHYS_W), .CNT_W(CNT_W)) u_rename_history_buf (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_seq(ins_seq), .ins_arch(ins_arch),
    .ins_new(ins_new), .ins_prev(ins_prev), .ins_hold(ins_hold),
    .ins_ready(ins_ready), .cmt_valid(cmt_valid), .cmt_seq(cmt_seq),
    .sq_valid(sq_valid), .sq_seq(sq_seq), .map_we(map_we),
    .map_arch(map_arch), .map_phys(map_phys), .free_we(free_we),
    .free_phys(free_phys), .busy(busy), .full(full),
    .cnt_hold(cnt_hold), .cnt_commit(cnt_commit), .cnt_undo(cnt_undo),
    .cnt_undo_valid(cnt_undo_valid)
  );

  typedef struct packed {
    logic [SEQ_W-1:0]  seq;
    logic [ARCH_W-1:0] arch;
    logic [PHYS_W-1:0] nw;
    logic [PHYS_W-1:0] pv;
    logic              hold;
  } ent_t;

  ent_t mq[$];
  logic [ARCH_W+PHYS_W-1:0] exp_map[$], got_map[$];
  logic [PHYS_W-1:0] exp_free[$], got_free[$];
  int m_hold = 0, m_commit = 0, m_undo = 0, m_uvalid = 0;
  int checks = 0, errors = 0, next_seq = 1, cyc = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void model_squash(input int s);
    while (mq.size() > 0 && int'(mq[$].seq) > s) begin
      ent_t e = mq.pop_back();
      m_undo++;
      if (!e.hold) begin
        m_uvalid++;
        exp_map.push_back({e.arch, e.pv});
        exp_free.push_back(e.nw);
      end
    end
  endfunction

  function automatic void model_commit(input int c);
    while (mq.size() > 0 && int'(mq[0].seq) <= c) begin
      ent_t e = mq.pop_front();
      if (!e.hold) begin
        m_commit++;
        exp_free.push_back(e.pv);
      end
    end
  endfunction

  task automatic check_counters(input string req);
    check(int'(cnt_hold) == m_hold, req, "cnt_hold", cnt_hold, m_hold);
    check(int'(cnt_commit) == m_commit, req, "cnt_commit", cnt_commit, m_commit);
    check(int'(cnt_undo) == m_undo, req, "cnt_undo", cnt_undo, m_undo);
    check(int'(cnt_undo_valid) == m_uvalid, req, "cnt_undo_valid", cnt_undo_valid, m_uvalid);
  endtask

  task automatic insert_one(input int seq, input bit hold, output bit acc);
    @(negedge clk);
    ins_valid = 1'b1;
    ins_seq   = SEQ_W'(seq);
    ins_hold  = hold;
    ins_arch  = hold ? '0 : ARCH_W'($urandom);
    ins_new   = hold ? '0 : PHYS_W'($urandom);
    ins_prev  = hold ? '0 : PHYS_W'($urandom);
    #1 acc = ins_ready;
    if (acc) begin
      mq.push_back({ins_seq, ins_arch, ins_new, ins_prev, ins_hold});
      if (hold) m_hold++;
    end
    @(negedge clk);
    ins_valid = 1'b0;
  endtask

  task automatic insert_instr(input int ndest);
    bit acc;
    if (ndest == 0) insert_one(next_seq, 1'b1, acc);
    else for (int d = 0; d < ndest; d++) insert_one(next_seq, 1'b0, acc);
    next_seq++;
  endtask

  // R3 R4 R6 R7 R8 R9: run one request, compare event streams with the model
  task automatic run_walk(input bit do_sq, input int s, input bit do_cm,
                          input int c, input bit poke, input string req);
    bit exp_busy;
    int n;
    exp_map.delete(); exp_free.delete(); got_map.delete(); got_free.delete();
    exp_busy = do_sq || (do_cm && mq.size() > 0 && int'(mq[0].seq) <= c);
    if (do_sq) model_squash(s);
    else if (do_cm) model_commit(c);
    @(negedge clk);
    sq_valid  = do_sq;  sq_seq  = SEQ_W'(s);
    cmt_valid = do_cm;  cmt_seq = SEQ_W'(c);
    ins_valid = 1'b1;   ins_seq = SEQ_W'(next_seq); ins_hold = 1'b0;
    #1 check(ins_ready == 1'b0, "R8", "ins_ready during request", ins_ready, 0);
    @(negedge clk);
    sq_valid = 1'b0; cmt_valid = 1'b0; ins_valid = 1'b0;
    check(busy == exp_busy, req, "busy after request", busy, exp_busy);
    n = 0;
    while (busy && n < 100) begin
      if (map_we)  got_map.push_back({map_arch, map_phys});
      if (free_we) got_free.push_back(free_phys);
      if (poke && n == 0) begin
        cmt_valid = 1'b1; cmt_seq = '1;
      end
      @(negedge clk);
      cmt_valid = 1'b0;
      n++;
    end
    check(got_map.size() == exp_map.size(), req, "map write count",
          got_map.size(), exp_map.size());
    for (int i = 0; i < got_map.size() && i < exp_map.size(); i++)
      if (got_map[i] != exp_map[i]) begin
        check(1'b0, req, "map write value", got_map[i], exp_map[i]);
        break;
      end
    check(got_free.size() == exp_free.size(), req, "free return count",
          got_free.size(), exp_free.size());
    for (int i = 0; i < got_free.size() && i < exp_free.size(); i++)
      if (got_free[i] != exp_free[i]) begin
        check(1'b0, req, "free return value", got_free[i], exp_free[i]);
        break;
      end
    check_counters("R10");
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int r, s, c;
    bit acc;
    void'($urandom(32'h5eed_0417));
    rst_n = 1'b0; ins_valid = 0; ins_hold = 0; ins_seq = '0; ins_arch = '0;
    ins_new = '0; ins_prev = '0; cmt_valid = 0; cmt_seq = '0;
    sq_valid = 0; sq_seq = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(busy == 0, "R11", "busy", busy, 0);
    check(full == 0, "R11", "full", full, 0);
    check(ins_ready == 1, "R11", "ins_ready", ins_ready, 1);
    check(map_we == 0 && free_we == 0, "R11", "write ports", {map_we, free_we}, 0);
    check_counters("R11");

    // R5 squash on empty, R7 commit on empty
    run_walk(1, 0, 0, 0, 0, "R5");
    run_walk(0, 0, 1, 5, 0, "R7");

    // R1 R3 R4 R6 R7 directed mix
    insert_instr(2); insert_instr(0); insert_instr(1); insert_instr(0);
    run_walk(0, 0, 1, 0, 0, "R7");
    run_walk(1, 2, 0, 0, 0, "R3");
    run_walk(0, 0, 1, 1, 0, "R6");
    insert_instr(1); insert_instr(1);

    // R8 squash wins over commit
    run_walk(1, int'(mq[0].seq), 1, next_seq, 0, "R8");
    // R9 commit poked during squash walk is ignored
    insert_instr(1); insert_instr(2); insert_instr(1);
    run_walk(1, int'(mq[0].seq), 0, 0, 1, "R9");
    run_walk(1, 0, 0, 0, 0, "R9");

    // R2 fill to capacity
    for (int i = 0; i < DEPTH; i++) insert_one(next_seq + i, 1'b0, acc);
    next_seq += DEPTH;
    @(negedge clk);
    check(full == 1, "R2", "full at capacity", full, 1);
    check(ins_ready == 0, "R2", "ins_ready when full", ins_ready, 0);
    insert_one(next_seq, 1'b0, acc);
    next_seq++;
    check(acc == 0, "R2", "insert accepted when full", acc, 0);
    check(mq.size() == DEPTH, "R2", "model depth", mq.size(), DEPTH);
    run_walk(0, 0, 1, int'(mq[3].seq), 0, "R6");
    run_walk(1, 0, 0, 0, 0, "R2");

    // random phase
    for (int it = 0; it < 400; it++) begin
      r = $urandom_range(0, 9);
      if (r < 6) begin
        insert_instr($urandom_range(0, 3) == 0 ? 0 : $urandom_range(1, 2));
      end else if (r < 8) begin
        if (mq.size() == 0) c = next_seq;
        else if ($urandom_range(0, 9) == 0) c = int'(mq[0].seq) - 1;
        else c = int'(mq[$urandom_range(0, mq.size() - 1)].seq);
        run_walk(0, 0, 1, c, 0, "R6");
      end else begin
        if (mq.size() == 0) s = next_seq - 1;
        else s = int'(mq[0].seq) - 1 + $urandom_range(0, next_seq - int'(mq[0].seq));
        run_walk(1, s, 0, 0, 0, "R3");
        if (s + 1 < next_seq) next_seq = s + 1;
      end
    end
    run_walk(1, 0, 0, 0, 0, "R3");
    check(full == 0, "R1", "full after drain", full, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule